// File: doc/BRIEF.md
# Split-Section Decade Ripple Counter

A four-bit counter made of two sections that work on their own or chained by outside wiring. The low section is a single divide-by-two stage with its own count input and a one-bit output. The high section is a divide-by-five stage with its own count input and a three-bit output. If the low output drives the high count input, the counter steps through binary-coded decimal. If the top bit of the high section drives the low count input, the counter runs in bi-quinary order, and the low output becomes a symmetrical square wave at one tenth of the input pulse rate.

Each stage advances on the falling edge of its count input. That edge is detected by sampling the input on a free-running system clock. Each stage therefore adds one system-clock cycle of delay, which models the ripple of a chained counter. A pair of clear inputs and a pair of preset inputs act at once, without waiting for a clock. A preset forces the value nine and takes priority over a clear. A system reset puts the counter and its edge detectors into a known state.

Top module: `decade_ripple_counter`

## Requirements
- R1: The low stage output `qLow` inverts at the first rising edge of `clk` at which `cntInLow` is sampled low after being sampled high. The high section does not change.
- R2: The high section steps `qHigh` through 0, 1, 2, 3, 4 and back to 0, advancing once for each falling edge of `cntInHigh` detected the same way. `qHigh` never holds a value above 4.
- R3: With `qLow` wired to `cntInHigh` and pulses applied to `cntInLow`, the value {qHigh, qLow} (qLow is bit 0) reads 1, 2, … 9, 0, 1, … after successive pulses.
- R4: With `qHigh[2]` wired to `cntInLow` and pulses applied to `cntInHigh`, `qLow` is 0 after pulses 1–4, 1 after pulses 5–9 and 0 after pulses 10–14. It is high for 5 of every 10 pulses.
- R5: While `clrReqA` and `clrReqB` are both high, both outputs are zero at once, with no clock edge needed. Counting is blocked while they are held. Either input alone has no effect.
- R6: While `nineReqA` and `nineReqB` are both high, the outputs are at once `qLow`=1 and `qHigh`=3'b100 (value 9), even while the clear pair is also active. Either input alone has no effect. When the preset is released while the clear is still held, the outputs clear at the next clock edge.
- R7: In the decimal wiring, a high-section step caused by `qLow` falling appears one `clk` cycle after `qLow` changes. For that one cycle the output holds an intermediate value.
- R8: A rising edge or a steady level on a count input leaves that section unchanged. One falling edge produces exactly one step.
- R9: While `sysRstN` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling and edge detection |
| sysRstN | input | 1 | Active-low system reset |
| cntInLow | input | 1 | Count input of the divide-by-two stage |
| cntInHigh | input | 1 | Count input of the divide-by-five section |
| clrReqA | input | 1 | Clear request, first of the ANDed pair |
| clrReqB | input | 1 | Clear request, second of the ANDed pair |
| nineReqA | input | 1 | Preset-to-nine request, first of the ANDed pair |
| nineReqB | input | 1 | Preset-to-nine request, second of the ANDed pair |
| qLow | output | 1 | Divide-by-two stage output |
| qHigh | output | 3 | Divide-by-five section output |

## Verification
Several properties are checked on every clock edge:
- each section's step against its modulus;
- each section's output range;
- the fact that a section holds when no edge is detected;
- the preset and clear values;
- the fact that a detected edge never repeats on the following cycle.

Other behaviour needs outside wiring, so only the bench scenarios can show it:
- the decimal sequence;
- the bi-quinary duty cycle;
- the one-cycle intermediate value between stages;
- the immediate effect of the clear and preset pairs between clock edges.

// File: rtl/rip_cnt_pkg.sv
package rip_cnt_pkg;
  localparam int NUM_SECT = 2;

  typedef struct packed {
    logic stepLow;
    logic stepHigh;
    logic clearAll;
    logic setNine;
  } strobe_t;
endpackage

// File: rtl/rip_cnt_stage.sv
module rip_cnt_stage #(
  parameter int MOD = 5,
  parameter int PRESET = MOD - 1,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         sysRstN,
  input  logic         step,
  input  logic         clearAll,
  input  logic         setNine,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] PRE  = W'(PRESET);

  logic [W-1:0] nextQ;
  assign nextQ = (q == LAST) ? '0 : W'(q + 1'b1);

  always_ff @(posedge clk or negedge sysRstN or posedge clearAll or posedge setNine) begin
    if (!sysRstN)     q <= '0;
    else if (setNine) q <= PRE;
    else if (clearAll) q <= '0;
    else if (step)    q <= nextQ;
  end

  // R2 (R1 for the two-state instance)
  step_wrap_chk: assert property (@(posedge clk) disable iff (!sysRstN || clearAll || setNine)
    step |=> q == (($past(q) == LAST) ? '0 : W'($past(q) + 1'b1)));

  // R2
  range_chk: assert property (@(posedge clk) disable iff (!sysRstN) q <= LAST);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!sysRstN || clearAll || setNine)
    !step |=> $stable(q));

  // R6
  nine_chk: assert property (@(posedge clk) disable iff (!sysRstN) setNine |-> q == PRE);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!sysRstN || setNine)
    (clearAll && !setNine) |=> q == '0);
endmodule

// File: rtl/rip_cnt_ctrl.sv
module rip_cnt_ctrl
  import rip_cnt_pkg::*;
(
  input  logic                clk,
  input  logic                sysRstN,
  input  logic [NUM_SECT-1:0] cntIn,
  input  logic [1:0]          clrPair,
  input  logic [1:0]          ninePair,
  output strobe_t             strobes
);
  logic [NUM_SECT-1:0] prevIn;
  logic [NUM_SECT-1:0] fallSeen;

  for (genvar g = 0; g < NUM_SECT; g++) begin : gEdge
    always_ff @(posedge clk or negedge sysRstN) begin
      if (!sysRstN) prevIn[g] <= 1'b0;
      else          prevIn[g] <= cntIn[g];
    end
    assign fallSeen[g] = prevIn[g] & ~cntIn[g];

    // R8
    one_step_chk: assert property (@(posedge clk) disable iff (!sysRstN)
      fallSeen[g] |=> !fallSeen[g]);
  end

  always_comb begin
    strobes.stepLow  = fallSeen[0];
    strobes.stepHigh = fallSeen[NUM_SECT-1];
    strobes.clearAll = &clrPair;
    strobes.setNine  = &ninePair;
  end
endmodule

// File: rtl/rip_cnt_datapath.sv
module rip_cnt_datapath
  import rip_cnt_pkg::*;
#(
  parameter int HIGH_MOD = 5,
  localparam int HIGH_W = $clog2(HIGH_MOD)
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  strobe_t           strobes,
  output logic              qLow,
  output logic [HIGH_W-1:0] qHigh
);
  logic clearAll;
  logic setNine;
  assign clearAll = strobes.clearAll;
  assign setNine  = strobes.setNine;

  rip_cnt_stage #(.MOD(2), .PRESET(1)) uLow (
    .clk(clk), .sysRstN(sysRstN), .step(strobes.stepLow),
    .clearAll(clearAll), .setNine(setNine), .q(qLow)
  );

  rip_cnt_stage #(.MOD(HIGH_MOD), .PRESET(HIGH_MOD - 1)) uHigh (
    .clk(clk), .sysRstN(sysRstN), .step(strobes.stepHigh),
    .clearAll(clearAll), .setNine(setNine), .q(qHigh)
  );
endmodule

// File: rtl/decade_ripple_counter.sv
module decade_ripple_counter
  import rip_cnt_pkg::*;
#(
  parameter int HIGH_MOD = 5,
  localparam int HIGH_W = $clog2(HIGH_MOD)
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              cntInLow,
  input  logic              cntInHigh,
  input  logic              clrReqA,
  input  logic              clrReqB,
  input  logic              nineReqA,
  input  logic              nineReqB,
  output logic              qLow,
  output logic [HIGH_W-1:0] qHigh
);
  strobe_t strobes;

  rip_cnt_ctrl uCtrl (
    .clk(clk), .sysRstN(sysRstN),
    .cntIn({cntInHigh, cntInLow}),
    .clrPair({clrReqB, clrReqA}),
    .ninePair({nineReqB, nineReqA}),
    .strobes(strobes)
  );

  rip_cnt_datapath #(.HIGH_MOD(HIGH_MOD)) uData (
    .clk(clk), .sysRstN(sysRstN), .strobes(strobes),
    .qLow(qLow), .qHigh(qHigh)
  );
endmodule

// File: tb/decade_ripple_counter_test.sv
module decade_ripple_counter_test;
  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic extLow = 1'b0, extHigh = 1'b0;
  logic clrReqA = 1'b0, clrReqB = 1'b0, nineReqA = 1'b0, nineReqB = 1'b0;
  int   wiring = 0; // 0 separate, 1 decimal, 2 bi-quinary
  logic qLow;
  logic [2:0] qHigh;
  logic cntInLow, cntInHigh;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign cntInLow  = (wiring == 2) ? qHigh[2] : extLow;
  assign cntInHigh = (wiring == 1) ? qLow : extHigh;

  always #4 clk = ~clk;

  decade_ripple_counter uut (
    .clk(clk), .sysRstN(sysRstN), .cntInLow(cntInLow), .cntInHigh(cntInHigh),
    .clrReqA(clrReqA), .clrReqB(clrReqB), .nineReqA(nineReqA), .nineReqB(nineReqB),
    .qLow(qLow), .qHigh(qHigh)
  );

  localparam int BCD_EXP [12] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 0, 1, 2};

  function automatic int value();
    return int'({qHigh, qLow});
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit onHigh);
    if (onHigh) extHigh = 1'b1; else extLow = 1'b1;
    cyc(2);
    if (onHigh) extHigh = 1'b0; else extLow = 1'b0;
    cyc(4);
  endtask

  task automatic restart(input int mode);
    sysRstN = 1'b0;
    wiring = mode;
    cyc(2);
    sysRstN = 1'b1;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R9 reset value", value(), 0);
    restart(0);

    // R1: low stage alone
    for (int i = 1; i <= 3; i++) begin
      pulse(1'b0);
      chk("R1 low toggle", int'(qLow), i % 2);
      chk("R1 high untouched", int'(qHigh), 0);
    end
    // R2: high section alone
    for (int i = 1; i <= 6; i++) begin
      pulse(1'b1);
      chk("R2 high step", int'(qHigh), i % 5);
      chk("R2 low untouched", int'(qLow), 1);
    end
    // R8: rising edge and held level do nothing
    extLow = 1'b1;
    cyc(5);
    chk("R8 rise no step", int'(qLow), 1);
    extLow = 1'b0;
    cyc(3);
    chk("R8 one fall one step", int'(qLow), 0);

    // R3: decimal wiring, table of expected values
    restart(1);
    for (int i = 0; i < 12; i++) begin
      pulse(1'b0);
      chk("R3 decimal sequence", value(), BCD_EXP[i]);
    end

    // R7: ripple between stages, from value 3 to 4
    pulse(1'b0);
    chk("R7 start value", value(), 3);
    extLow = 1'b1;
    cyc(2);
    extLow = 1'b0;
    cyc(1);
    chk("R7 intermediate value", value(), 2);
    cyc(1);
    chk("R7 settled value", value(), 4);
    cyc(2);

    // R5: clear pair
    clrReqA = 1'b1;
    pulse(1'b0);
    chk("R5 single clear ignored", value(), 5);
    clrReqB = 1'b1;
    #1;
    chk("R5 clear immediate", value(), 0);
    pulse(1'b0);
    chk("R5 clear blocks count", value(), 0);
    clrReqA = 1'b0;
    clrReqB = 1'b0;
    cyc(2);
    pulse(1'b0);
    chk("R5 count after release", value(), 1);

    // R6: preset pair
    nineReqB = 1'b1;
    cyc(2);
    chk("R6 single preset ignored", value(), 1);
    nineReqA = 1'b1;
    #1;
    chk("R6 preset immediate", value(), 9);
    cyc(1);
    nineReqA = 1'b0;
    nineReqB = 1'b0;
    cyc(2);
    pulse(1'b0);
    chk("R6 nine wraps to zero", value(), 0);
    clrReqA = 1'b1;
    clrReqB = 1'b1;
    cyc(2);
    nineReqA = 1'b1;
    nineReqB = 1'b1;
    #1;
    chk("R6 preset beats clear", value(), 9);
    cyc(2);
    nineReqA = 1'b0;
    nineReqB = 1'b0;
    cyc(2);
    chk("R6 clear after preset release", value(), 0);
    clrReqA = 1'b0;
    clrReqB = 1'b0;
    cyc(2);

    // R4: bi-quinary wiring
    restart(2);
    begin
      int highCnt = 0;
      for (int n = 1; n <= 20; n++) begin
        pulse(1'b1);
        chk("R4 low square wave", int'(qLow), (n / 5) % 2);
        chk("R4 high count", int'(qHigh), n % 5);
        if (n > 10 && qLow) highCnt++;
      end
      chk("R4 duty over ten pulses", highCnt, 5);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule